// File: doc/BRIEF.md
# Eight-bit accumulator processor with symmetric operand addressing

This block is a small 8-bit accumulator processor that runs code out of a single 8-bit read/write memory. Each instruction takes two bytes: an opcode byte followed by an address byte. Only the low four bits of the opcode byte are decoded. Bit 3 of the opcode picks the operand source for every instruction. When it is clear, the operand is the memory byte at the address field. When it is set, the address byte itself is the operand. The same bit turns the conditional branch into an unconditional one.

An instruction takes three clock cycles. In the first cycle the processor reads the opcode at the program counter and increments the counter. In the second cycle it reads the address byte at the new counter value. In the third cycle it puts the address field on the memory bus, runs the ALU or does the store, and updates the program counter. The memory has a combinational read and a write that happens on the clock edge. It sits outside the block, next to it in the system.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `mem_we` is 0 and `mem_addr` is 0x00. After release, the first opcode is read from address 0x00 and the accumulator starts at 0x00.
- R2: The three cycles after release, and each group of three that follows, put these addresses on `mem_addr` in order: the opcode address, the opcode address plus 1, and then the instruction's address field. The accumulator changes only at the end of the third cycle.
- R3: These opcodes use the memory byte at the address field: 0 loads it, 3 adds it, 4 subtracts it, 5 ANDs it and 6 ORs it. Opcode 2 inverts the accumulator.
- R4: Opcodes 8, 11, 12, 13 and 14 load, add, subtract, AND and OR the address byte itself instead of the memory byte.
- R5: Subtraction is 8-bit two's complement and drops the borrow, so 0x85 minus 0x90 gives 0xF5.
- R6: Opcode 1 writes the accumulator to the address field. `mem_we` is high only in the third cycle of that instruction, and the accumulator is not changed.
- R7: Opcode 7 adds the address byte to the program counter only when the accumulator is 0x00. Otherwise execution continues at the opcode address plus 2.
- R8: Opcode 15 always adds the address byte to the program counter, whatever value the accumulator holds.
- R9: A branch target is the opcode address plus 1 plus the offset, modulo 256. An offset of 0xFF re-executes the same branch forever. Offset 0xF1 at address 0x12 goes to 0x04.
- R10: Bits 7..4 of the opcode byte have no effect. For example, 0xF8 acts as opcode 8 and 0x71 acts as opcode 1.
- R11: Opcodes 9 and 10 do not change the accumulator and do not write memory. Every instruction that does not branch moves the program counter on by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Data to write to memory (the accumulator) |
| mem_rdata | input | 8 | Combinational read data at `mem_addr` |
| mem_we | output | 1 | Write strobe, active high |

## Verification
The bench tracks the cycle index since reset release and uses it to place each result. The opcode address is expected in cycles where the index mod 3 is 0, the address-byte address in cycles 1 mod 3, and the operand address or a store in cycles 2 mod 3. Accumulator results cannot be seen at the ports, so each program stores them, and each store is due on `mem_we` in the third cycle of its store instruction. The driver queues every write it expects, in program order. A monitor checks each write on the falling clock edge, so a missing, extra or reordered write is caught as soon as it happens. A halt is checked by sampling `mem_addr` on an opcode-phase cycle, well after the last expected write.

// File: rtl/acc_cpu.sv
module acc_cpu (
  input  logic       clk,
  input  logic       rst_n,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata,
  output logic       mem_we
);
  typedef enum logic [1:0] {PH_OP, PH_AD, PH_EX} phase_t;

  phase_t     phase;
  logic [7:0] pc, acc, adr;
  logic [3:0] code;
  logic [7:0] opnd, alu;
  logic       take;

  assign opnd      = code[3] ? adr : mem_rdata;
  assign take      = (code[2:0] == 3'd7) && (code[3] || acc == 8'h00);
  assign mem_addr  = (phase == PH_EX) ? adr : pc;
  assign mem_wdata = acc;
  assign mem_we    = (phase == PH_EX) && (code == 4'd1);

  always_comb begin
    case (code[2:0])
      3'd0:    alu = opnd;
      3'd2:    alu = code[3] ? acc : ~acc;
      3'd3:    alu = acc + opnd;
      3'd4:    alu = acc - opnd;
      3'd5:    alu = acc & opnd;
      3'd6:    alu = acc | opnd;
      default: alu = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OP;
      pc    <= 8'h00;
      acc   <= 8'h00;
      adr   <= 8'h00;
      code  <= 4'h0;
    end else begin
      case (phase)
        PH_OP: begin
          code  <= mem_rdata[3:0];
          pc    <= pc + 8'd1;
          phase <= PH_AD;
        end
        PH_AD: begin
          adr   <= mem_rdata;
          phase <= PH_EX;
        end
        default: begin
          acc   <= alu;
          pc    <= take ? pc + adr : pc + 8'd1;
          phase <= PH_OP;
        end
      endcase
    end
  end

  AST_ACC_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_EX |=> $stable(acc)); // R2
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> $stable(acc)); // R6
  AST_NO_BRANCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EX && !take) |=> pc == $past(pc) + 8'd1); // R11
  AST_HALT_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EX && take && adr == 8'hFF) |=> pc == $past(pc) - 8'd1); // R9
  AST_UNUSED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EX && (code == 4'd9 || code == 4'd10)) |=> $stable(acc) && !$past(mem_we)); // R11
endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;
  logic [7:0] mem [256];
  logic [15:0] expq [$];
  int unsigned cyc = 0;
  int total = 0;
  int bad = 0;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we)
  );

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
    expq.push_back({a, d});
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (expq.size() == 0) chk("R6 unexpected write", {mem_addr, mem_wdata}, 16'hxxxx);
      else chk("R6 store addr/data", {mem_addr, mem_wdata}, expq.pop_front());
    end
  end

  task automatic put(input logic [7:0] a, input logic [7:0] op, input logic [7:0] ad);
    mem[a] = op;
    mem[a + 8'd1] = ad;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    expq.delete();
  endtask

  task automatic start();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset we", {15'd0, mem_we}, 16'd0);
    chk("R1 reset addr", {8'd0, mem_addr}, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic finish_prog(input string tag, input int cycles, input logic [7:0] halt);
    repeat (cycles) @(negedge clk);
    while (cyc % 3 != 0) @(negedge clk);
    chk({tag, " halt address"}, {8'd0, mem_addr}, {8'd0, halt});
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk({tag, " halt stays"}, {8'd0, mem_addr}, {8'd0, halt});
    chk({tag, " all writes seen"}, 16'(expq.size()), 16'd0);
  endtask

  task automatic run_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] res;
    clear_mem();
    put(8'h00, 8'h08, 8'h00);
    put(8'h02, 8'h01, 8'hFF);
    put(8'h04, 8'h00, 8'hFE);
    put(8'h06, 8'h07, 8'h0D);
    put(8'h08, 8'h0C, 8'h01);
    put(8'h0A, 8'h01, 8'hFE);
    put(8'h0C, 8'h00, 8'hFF);
    put(8'h0E, 8'h03, 8'hFD);
    put(8'h10, 8'h01, 8'hFF);
    put(8'h12, 8'h0F, 8'hF1);
    put(8'h14, 8'h0F, 8'hFF);
    mem[8'hFD] = a;
    mem[8'hFE] = b;
    res = 8'h00;
    push_wr(8'hFF, 8'h00);
    for (int i = int'(b) - 1; i >= 0; i--) begin
      push_wr(8'hFE, 8'(i));
      res = res + a;
      push_wr(8'hFF, res);
    end
    start();
    finish_prog("R7 R8 R9 multiply", 30 * (int'(b) + 2), 8'h14);
    chk("R7 R8 product", {8'd0, mem[8'hFF]}, {8'd0, 8'(a * b)});
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mem();
    mem[8'hE0] = 8'h5A; mem[8'hE1] = 8'h0F; mem[8'hE2] = 8'h30;
    put(8'h00, 8'h00, 8'hE0); put(8'h02, 8'h01, 8'hC0);
    put(8'h04, 8'h03, 8'hE1); put(8'h06, 8'h01, 8'hC1);
    put(8'h08, 8'h04, 8'hE2); put(8'h0A, 8'h01, 8'hC2);
    put(8'h0C, 8'h05, 8'hE1); put(8'h0E, 8'h01, 8'hC3);
    put(8'h10, 8'h06, 8'hE2); put(8'h12, 8'h01, 8'hC4);
    put(8'h14, 8'h02, 8'h00); put(8'h16, 8'h01, 8'hC5);
    put(8'h18, 8'h08, 8'h80); put(8'h1A, 8'h0B, 8'h05);
    put(8'h1C, 8'h01, 8'hC6); put(8'h1E, 8'h0C, 8'h90);
    put(8'h20, 8'h01, 8'hC7); put(8'h22, 8'h0D, 8'h3C);
    put(8'h24, 8'h0E, 8'h41); put(8'h26, 8'h01, 8'hC8);
    put(8'h28, 8'hF8, 8'h22); put(8'h2A, 8'h71, 8'hC9);
    put(8'h2C, 8'h09, 8'hC0); put(8'h2E, 8'h0A, 8'h00);
    put(8'h30, 8'h01, 8'hCA); put(8'h32, 8'h0F, 8'hFF);
    push_wr(8'hC0, 8'h5A);   // R3 load
    push_wr(8'hC1, 8'h69);   // R3 add
    push_wr(8'hC2, 8'h39);   // R3 sub
    push_wr(8'hC3, 8'h09);   // R3 and
    push_wr(8'hC4, 8'h39);   // R3 or
    push_wr(8'hC5, 8'hC6);   // R3 not
    push_wr(8'hC6, 8'h85);   // R4 load/add immediate
    push_wr(8'hC7, 8'hF5);   // R5 wrap on subtract
    push_wr(8'hC8, 8'h75);   // R4 and/or immediate
    push_wr(8'hC9, 8'h22);   // R10 upper bits ignored
    push_wr(8'hCA, 8'h22);   // R11 unused opcodes inert
    start();
    chk("R2 opcode fetch addr", {8'd0, mem_addr}, 16'h0000);
    @(negedge clk);
    chk("R2 address byte addr", {8'd0, mem_addr}, 16'h0001);
    @(negedge clk);
    chk("R2 operand addr", {8'd0, mem_addr}, 16'h00E0);
    @(negedge clk);
    chk("R2 next opcode addr", {8'd0, mem_addr}, 16'h0002);
    finish_prog("R9 R11 program A", 3 * 26 + 6, 8'h32);
    chk("R11 opcode 9 wrote nothing", {8'd0, mem[8'hC0]}, 16'h005A);

    run_mul(8'h07, 8'h05);
    run_mul(8'h09, 8'h00);
    run_mul(8'h30, 8'h06);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule